// File: doc/BRIEF.md
# I2C Master Address and Repeated-Start Sequencer

This block sits between the register side of an I2C master and its bit-level engine. A write to the first address register starts a transaction. The block then sends the engine a series of byte-level commands: START, the address byte or bytes, data writes or reads, and a final STOP or a repeated start. Each command goes out with a valid/ready handshake. The block waits for the engine's done pulse before it moves on. With the done pulse the engine also returns the acknowledge state.

Firmware asks for a repeated start by writing the first address register again while a transaction is still running. The block holds that request. It acts on it only when the current phase ends: when the transmit FIFO runs empty on a write, or when the requested number of bytes has been received on a read. A 10-bit read is built in full. The block sends both address bytes with the direction bit cleared, then a repeated start, then the first byte again with the direction bit set.

The same block also produces the bus-rate tick. The tick rate is standard (100 kHz) or fast (400 kHz), taken from a 20 MHz clock. A power-saving pre-divider divides that clock, and the tick count is recomputed from the divided rate.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `err` and `scl_tick` are all 0.
- R2: Command codes on `cmd_op` are 1=START, 2=RESTART, 3=address write (byte on `cmd_byte`), 4=data write (byte supplied by the engine), 5=read and 6=STOP. `cmd_valid` and its op and byte stay unchanged until `cmd_ready` is seen. After a command is accepted, no new command is offered until `cmd_done` has pulsed.
- R3: In 7-bit mode, `adr0_wr` while idle raises `busy` and issues START, then an address write carrying `adr0_data` unchanged. Bit 0 of that byte is the direction bit: 1 means read.
- R4: In a write, a data write is issued for as long as `tx_empty` is 0. When `tx_empty` is 1 and no restart is pending, STOP is issued, and `busy` falls after the STOP is done.
- R5: In a read, exactly `rx_count` reads are issued, followed by STOP. If `rx_count` is 0, STOP follows the address directly.
- R6: `adr0_wr` during a transaction becomes a pending restart only once the first address byte is in progress. A write made while START is still outstanding is ignored.
- R7: A restart pending during a write is issued when the transmit FIFO is empty. It is followed by the new first address byte.
- R8: A restart pending during a read is issued once `rx_count` bytes have been read.
- R9: With `ten_bit_en`=1 and bit 0 of the first byte at 0, the block sends the first byte, then the byte last written through `adr1_wr`, then the data.
- R10: With `ten_bit_en`=1 and bit 0 of the first byte at 1, the block sends the first byte with bit 0 cleared, then the second byte, then RESTART, then the first byte with bit 0 set, then the reads.
- R11: A NACK on any address byte is followed by STOP and sets `err`. `err` stays at 1 until the next transaction starts.
- R12: The base count is 200 in standard mode (`fast_mode`=0) and 50 in fast mode. `scl_tick` pulses every 2^n × max(1, base >> n) clock cycles, where n is `pre_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adr0_wr | input | 1 | Write strobe for the first address byte |
| adr0_data | input | 8 | First address byte, bit 0 is the direction |
| adr1_wr | input | 1 | Write strobe for the second 10-bit address byte |
| adr1_data | input | 8 | Low eight bits of a 10-bit address |
| ten_bit_en | input | 1 | Selects 10-bit addressing, sampled at transaction start |
| tx_empty | input | 1 | Transmit FIFO is empty |
| rx_count | input | CNT_W | Number of bytes to read in a read phase |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_done | input | 1 | Engine finished the accepted command |
| cmd_nack | input | 1 | Acknowledge was missing, valid with `cmd_done` |
| cmd_valid | output | 1 | A command is offered |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Address byte for address-write commands |
| busy | output | 1 | A transaction is running |
| err | output | 1 | The last transaction ended on an address NACK |
| fast_mode | input | 1 | 1 selects 400 kHz, 0 selects 100 kHz |
| pre_div | input | 3 | Clock pre-divider exponent |
| scl_tick | output | 1 | Bus-rate tick pulse |

## Verification
The hardest situation to bring about is a restart request that lands in the right window. The `adr0_wr` strobe has to arrive while a particular command is outstanding: after the address byte has begun for R6 and R7, or while START is still unfinished for the ignored case. The bench plays the bit engine itself. It counts the commands it has accepted and raises the strobe one nanosecond after it sees command number k, so the window is hit exactly. A reference queue of expected commands, built from the requirements for each scenario, is consumed one entry per command.

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq #(
  parameter int STD_DIV  = 200,
  parameter int FAST_DIV = 50,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adr0_wr,
  input  logic [7:0]       adr0_data,
  input  logic             adr1_wr,
  input  logic [7:0]       adr1_data,
  input  logic             ten_bit_en,
  input  logic             tx_empty,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             cmd_ready,
  input  logic             cmd_done,
  input  logic             cmd_nack,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             busy,
  output logic             err,
  input  logic             fast_mode,
  input  logic [2:0]       pre_div,
  output logic             scl_tick
);
  localparam int MAXDIV = (STD_DIV > FAST_DIV) ? STD_DIV : FAST_DIV;
  localparam int TW     = $clog2(MAXDIV + 1) + 1;

  localparam logic [2:0] OP_START = 3'd1, OP_RS = 3'd2, OP_ADDR = 3'd3,
                         OP_WDAT  = 3'd4, OP_READ = 3'd5, OP_STOP = 3'd6;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_A0W, S_A1, S_RS10, S_A0R, S_DATA, S_RSTRT, S_STOP
  } st_t;

  st_t              st;
  logic             waiting, ten, pend, err_q;
  logic [7:0]       a0, a1, pend_a0;
  logic [CNT_W-1:0] rcnt;

  wire rd        = a0[0];
  wire data_more = rd ? (rcnt != rx_count) : !tx_empty;
  wire take      = cmd_valid && cmd_ready;
  wire in_addr   = (st == S_A0W) || (st == S_A1) || (st == S_RS10) ||
                   (st == S_A0R) || (st == S_DATA) || (st == S_RSTRT);

  assign busy      = (st != S_IDLE);
  assign err       = err_q;
  assign cmd_valid = busy && !waiting && ((st != S_DATA) || data_more);

  always_comb begin
    cmd_op   = 3'd0;
    cmd_byte = 8'd0;
    case (st)
      S_START:         cmd_op = OP_START;
      S_A0W: begin
        cmd_op   = OP_ADDR;
        cmd_byte = (ten && rd) ? {a0[7:1], 1'b0} : a0;
      end
      S_A1:            begin cmd_op = OP_ADDR; cmd_byte = a1; end
      S_A0R:           begin cmd_op = OP_ADDR; cmd_byte = a0; end
      S_RS10, S_RSTRT: cmd_op = OP_RS;
      S_DATA:          cmd_op = rd ? OP_READ : OP_WDAT;
      S_STOP:          cmd_op = OP_STOP;
      default:         cmd_op = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      waiting <= 1'b0;
      ten     <= 1'b0;
      pend    <= 1'b0;
      err_q   <= 1'b0;
      a0      <= 8'd0;
      a1      <= 8'd0;
      pend_a0 <= 8'd0;
      rcnt    <= '0;
    end else begin
      if (adr1_wr) a1 <= adr1_data;
      if (st == S_IDLE) begin
        if (adr0_wr) begin
          a0    <= adr0_data;
          ten   <= ten_bit_en;
          err_q <= 1'b0;
          pend  <= 1'b0;
          st    <= S_START;
        end
      end else begin
        if (take) waiting <= 1'b1;
        if (take && st == S_RSTRT) begin
          a0   <= pend_a0;
          pend <= 1'b0;
        end
        if (waiting && cmd_done) begin
          waiting <= 1'b0;
          case (st)
            S_START, S_RSTRT: st <= S_A0W;
            S_A0W:
              if (cmd_nack) begin st <= S_STOP; err_q <= 1'b1; end
              else if (ten) st <= S_A1;
              else begin st <= S_DATA; rcnt <= '0; end
            S_A1:
              if (cmd_nack) begin st <= S_STOP; err_q <= 1'b1; end
              else if (rd) st <= S_RS10;
              else begin st <= S_DATA; rcnt <= '0; end
            S_RS10: st <= S_A0R;
            S_A0R:
              if (cmd_nack) begin st <= S_STOP; err_q <= 1'b1; end
              else begin st <= S_DATA; rcnt <= '0; end
            S_DATA: if (rd) rcnt <= rcnt + 1'b1;
            S_STOP: begin st <= S_IDLE; pend <= 1'b0; end
            default: st <= S_IDLE;
          endcase
        end
        if (st == S_DATA && !waiting && !data_more)
          st <= pend ? S_RSTRT : S_STOP;
        if (adr0_wr && in_addr) begin
          pend    <= 1'b1;
          pend_a0 <= adr0_data;
        end
      end
    end
  end

  logic [6:0]    pre;
  logic [TW-1:0] tcnt, base, lim;
  logic          tick_q;
  wire  [6:0]    pmask = (7'd1 << pre_div) - 7'd1;
  wire           en    = ((pre & pmask) == pmask);

  always_comb begin
    base = fast_mode ? TW'(FAST_DIV) : TW'(STD_DIV);
    lim  = base >> pre_div;
    if (lim == '0) lim = TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      tcnt   <= '0;
      tick_q <= 1'b0;
    end else begin
      pre    <= pre + 7'd1;
      tick_q <= 1'b0;
      if (en) begin
        if (tcnt >= lim - TW'(1)) begin
          tcnt   <= '0;
          tick_q <= 1'b1;
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
    end
  end

  assign scl_tick = tick_q;

  a_r2_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);
  a_r11_err_from_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_done && cmd_nack));
  a_r4_end_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_done));
endmodule

// File: tb/sim_i2c_addr_seq.sv
`timescale 1ns/1ps
module sim_i2c_addr_seq;
  localparam int OP_START = 1, OP_RS = 2, OP_ADDR = 3, OP_WDAT = 4, OP_READ = 5, OP_STOP = 6;

  logic       clk = 0, rst_n = 0;
  logic       adr0_wr = 0, adr1_wr = 0, ten_bit_en = 0;
  logic [7:0] adr0_data = 0, adr1_data = 0, rx_count = 0;
  logic       cmd_ready = 0, cmd_done = 0, cmd_nack = 0;
  logic       cmd_valid, busy, err, scl_tick;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic       fast_mode = 0;
  logic [2:0] pre_div = 0;
  logic       tx_empty;

  int tx_left = 0, seen = 0, trig_idx = 0, total = 0, bad = 0;
  logic [7:0] trig_val = 0;
  bit finished = 0;
  int exp_op[$];
  int exp_byte[$];
  bit exp_nack[$];

  assign tx_empty = (tx_left == 0);
  always #4 clk = ~clk;

  i2c_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .adr0_wr(adr0_wr), .adr0_data(adr0_data),
    .adr1_wr(adr1_wr), .adr1_data(adr1_data), .ten_bit_en(ten_bit_en),
    .tx_empty(tx_empty), .rx_count(rx_count), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .cmd_nack(cmd_nack), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .busy(busy), .err(err),
    .fast_mode(fast_mode), .pre_div(pre_div), .scl_tick(scl_tick));

  task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input int op, input int b, input bit nk);
    exp_op.push_back(op); exp_byte.push_back(b); exp_nack.push_back(nk);
  endtask

  // bit engine stand-in: checks each offered command against the model queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        int op, b;
        bit nk;
        seen++;
        op = cmd_op; b = cmd_byte; nk = 0;
        if (exp_op.size() == 0) chk(0, "R2", op, 0, "unexpected command");
        else begin
          int eo, eb;
          eo = exp_op.pop_front(); eb = exp_byte.pop_front(); nk = exp_nack.pop_front();
          chk(op == eo, "R2", op, eo, "command code");
          if (eo == OP_ADDR) chk(b == eb, "R3/R9/R10", b, eb, "address byte");
        end
        cmd_ready = 1;
        if (seen == trig_idx) begin #1; adr0_wr = 1; adr0_data = trig_val; end
        @(negedge clk);
        cmd_ready = 0;
        if (seen == trig_idx) adr0_wr = 0;
        chk(!cmd_valid, "R2", cmd_valid, 0, "offer after accept");
        @(negedge clk);
        if (op == OP_WDAT && tx_left > 0) tx_left--;
        cmd_done = 1; cmd_nack = nk;
        @(negedge clk);
        cmd_done = 0; cmd_nack = 0;
      end
    end
  end

  task automatic run(input [7:0] a0, input bit t10, input int ntx, input int nrx,
                     input int tidx, input [7:0] tval, input bit xerr, input string req);
    ten_bit_en = t10; tx_left = ntx; rx_count = nrx[7:0];
    trig_idx = tidx; trig_val = tval; seen = 0;
    @(negedge clk); adr0_wr = 1; adr0_data = a0;
    @(negedge clk); adr0_wr = 0;
    chk(busy == 1, "R3", busy, 1, {"busy after start ", req});
    chk(err == 0, "R11", err, 0, {"err cleared at start ", req});
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    chk(busy == 0, "R4", busy, 0, {"busy falls ", req});
    chk(exp_op.size() == 0, req, exp_op.size(), 0, "commands left unissued");
    chk(err == xerr, "R11", err, xerr, {"err at end ", req});
    exp_op.delete(); exp_byte.delete(); exp_nack.delete();
    repeat (3) @(negedge clk);
  endtask

  function automatic int tick_period(input bit fm, input int n);
    int b, l;
    b = fm ? 50 : 200;
    l = b >> n;
    if (l == 0) l = 1;
    return l << n;
  endfunction

  task automatic tick_case(input bit fm, input int n);
    int t, e;
    fast_mode = fm; pre_div = n[2:0];
    repeat (600) @(negedge clk);
    for (int i = 0; i < 3000 && !scl_tick; i++) @(negedge clk);
    t = 0;
    @(negedge clk);
    for (int i = 0; i < 3000 && !scl_tick; i++) begin t++; @(negedge clk); end
    e = tick_period(fm, n);
    chk(t + 1 == e, "R12", t + 1, e, "tick period");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && cmd_valid == 0 && err == 0 && scl_tick == 0, "R1",
        {busy, cmd_valid, err, scl_tick}, 0, "reset outputs");
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cmd_valid == 0, "R1", {busy, cmd_valid}, 0, "idle after reset");

    // R3 R4: 7-bit write, two bytes
    push(OP_START,0,0); push(OP_ADDR,8'hA4,0); push(OP_WDAT,0,0); push(OP_WDAT,0,0); push(OP_STOP,0,0);
    run(8'hA4, 0, 2, 0, 0, 0, 0, "R4");
    // R5: 7-bit read, three bytes
    push(OP_START,0,0); push(OP_ADDR,8'hA5,0); push(OP_READ,0,0); push(OP_READ,0,0); push(OP_READ,0,0); push(OP_STOP,0,0);
    run(8'hA5, 0, 0, 3, 0, 0, 0, "R5");
    // R5: read count zero
    push(OP_START,0,0); push(OP_ADDR,8'h33,0); push(OP_STOP,0,0);
    run(8'h33, 0, 0, 0, 0, 0, 0, "R5");
    // R6 R7: write, restart into read
    push(OP_START,0,0); push(OP_ADDR,8'h50,0); push(OP_WDAT,0,0); push(OP_RS,0,0);
    push(OP_ADDR,8'h51,0); push(OP_READ,0,0); push(OP_READ,0,0); push(OP_STOP,0,0);
    run(8'h50, 0, 1, 2, 2, 8'h51, 0, "R7");
    // R8: read, restart into write
    push(OP_START,0,0); push(OP_ADDR,8'h61,0); push(OP_READ,0,0); push(OP_RS,0,0);
    push(OP_ADDR,8'h60,0); push(OP_WDAT,0,0); push(OP_STOP,0,0);
    run(8'h61, 0, 1, 1, 2, 8'h60, 0, "R8");
    // R6: write during START is ignored
    push(OP_START,0,0); push(OP_ADDR,8'h40,0); push(OP_WDAT,0,0); push(OP_STOP,0,0);
    run(8'h40, 0, 1, 0, 1, 8'h41, 0, "R6");
    // R9: 10-bit write
    @(negedge clk); adr1_wr = 1; adr1_data = 8'h3C; @(negedge clk); adr1_wr = 0;
    push(OP_START,0,0); push(OP_ADDR,8'hF2,0); push(OP_ADDR,8'h3C,0); push(OP_WDAT,0,0); push(OP_STOP,0,0);
    run(8'hF2, 1, 1, 0, 0, 0, 0, "R9");
    // R10: 10-bit read
    push(OP_START,0,0); push(OP_ADDR,8'hF2,0); push(OP_ADDR,8'h3C,0); push(OP_RS,0,0);
    push(OP_ADDR,8'hF3,0); push(OP_READ,0,0); push(OP_READ,0,0); push(OP_STOP,0,0);
    run(8'hF3, 1, 0, 2, 0, 0, 0, "R10");
    // R11: NACK on 7-bit address
    push(OP_START,0,0); push(OP_ADDR,8'h20,1); push(OP_STOP,0,0);
    run(8'h20, 0, 2, 0, 0, 0, 1, "R11");
    // R11: NACK on second 10-bit byte
    push(OP_START,0,0); push(OP_ADDR,8'hF2,0); push(OP_ADDR,8'h3C,1); push(OP_STOP,0,0);
    run(8'hF2, 1, 1, 0, 0, 0, 1, "R11");
    // R11: err cleared by a clean transaction
    push(OP_START,0,0); push(OP_ADDR,8'h12,0); push(OP_STOP,0,0);
    run(8'h12, 0, 0, 0, 0, 0, 0, "R11");

    // R12: tick rates
    tick_case(0, 0);
    tick_case(1, 0);
    tick_case(1, 2);
    tick_case(0, 3);
    tick_case(1, 7);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule